// File: doc/BRIEF.md
# Two-Phase System Bus Interface

This block sits between a processor core and an external system bus whose timing is set by two staggered clock phases. Each phase is presented to the block as a one-cycle rising-edge strobe on a fast system clock, and the first phase is also supplied as a level. The address and the write data are taken from the core at the second-phase rising edge and held until the next one. The block gives the bus a 16-bit address, a read/write line, and an 8-bit bidirectional data path.

The direction flag is not edge-triggered. It is a level-sensitive stage that follows the core's request for as long as the first phase is high, and it freezes while that phase is low. The write data stage is the only stage that drives the bus. Its drivers turn off whenever the read/write line reads high. Read data is captured into an input register at the first-phase rising edge. A system integrator wires the strobes from the clock generator, connects the core's address, direction and write data, and reads the captured byte from `in_data`.

Top module: `tpbus_if`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `addr_bus` = 0, `rw_line` = 1 (read), `bus_oe` = 0 and `in_data` = 0.
- R2: On the clock after an edge with `ph2_rise` = 1, `addr_bus` equals the `core_addr` present at that edge.
- R3: On every edge with `ph2_rise` = 0, `addr_bus` keeps its value, whatever `core_addr` does.
- R4: On the clock after an edge with `ph1_level` = 1, `rw_line` equals the `core_rd` present at that edge (1 = read, 0 = write).
- R5: On every edge with `ph1_level` = 0, `rw_line` keeps its value, whatever `core_rd` does.
- R6: `bus_oe` is 1 exactly when `rw_line` is 0, so the block never drives `data_bus` while the line signals a read.
- R7: While `bus_oe` is 1, `data_bus` carries the `core_wdata` taken at the most recent edge with `ph2_rise` = 1.
- R8: On the clock after an edge with `ph1_rise` = 1 and `core_rd` = 1, `in_data` equals the value on `data_bus` at that edge.
- R9: At every other edge, and in particular at a `ph1_rise` edge with `core_rd` = 0, `in_data` keeps its value.
- R10: A run of consecutive bus cycles of the same direction keeps `rw_line` constant for the whole run, with no toggle between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ph1_rise | input | 1 | One-cycle strobe at the rising edge of phase 1 |
| ph2_rise | input | 1 | One-cycle strobe at the rising edge of phase 2 |
| ph1_level | input | 1 | Level of phase 1 |
| core_addr | input | 16 | Address requested by the core |
| core_rd | input | 1 | Direction requested by the core, 1 = read |
| core_wdata | input | 8 | Write data from the core |
| data_bus | inout | 8 | Bidirectional system data bus |
| addr_bus | output | 16 | System address bus |
| rw_line | output | 1 | Read/write line, high = read |
| bus_oe | output | 1 | Output enable of the data-bus drivers |
| in_data | output | 8 | Byte captured from the bus in a read cycle |

## Verification
The assertions check on every cycle that the address and input registers load only on their own strobes and hold otherwise. They also check that the direction stage follows the core only while phase 1 is high, that the drivers are off whenever the line reads high, and that driven data matches the latest write byte. The bench scenarios are needed to show that behaviour holds over whole bus cycles: read data placed on the bus by a device arrives intact, and runs of reads or writes keep the direction line free of toggles. The bench also covers the cycle right after reset and direction changes that the core requests while phase 1 is low.

// File: rtl/tpbus_pkg.sv
package tpbus_pkg;
  localparam int unsigned ADDR_W_DEF = 16;
  localparam int unsigned DATA_W_DEF = 8;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;

  localparam logic RW_RESET = DIR_READ;
endpackage

// File: rtl/tpbus_addr_stage.sv
module tpbus_addr_stage #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  // Address and outgoing data share the phase-2 load point.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end
endmodule

// File: rtl/tpbus_rw_stage.sv
module tpbus_rw_stage
  import tpbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic open_en,
  input  logic rd_req,
  output logic rw_q,
  output logic oe_q
);
  // Level-enabled stage: follows the request while the enable is high.
  // The output enable is kept in its own flop so that it leaves a register.
  always_ff @(posedge clk) begin
    if (rst) begin
      rw_q <= RW_RESET;
      oe_q <= ~RW_RESET;
    end else if (open_en) begin
      rw_q <= rd_req;
      oe_q <= ~rd_req;
    end
  end
endmodule

// File: rtl/tpbus_in_stage.sv
module tpbus_in_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] data_q
);
  logic take;
  assign take = strobe & rd_req;

  always_ff @(posedge clk) begin
    if (rst)       data_q <= '0;
    else if (take) data_q <= bus_in;
  end
endmodule

// File: rtl/tpbus_if.sv
module tpbus_if #(
  parameter int unsigned ADDR_W = tpbus_pkg::ADDR_W_DEF,
  parameter int unsigned DATA_W = tpbus_pkg::DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ph1_rise,
  input  logic              ph2_rise,
  input  logic              ph1_level,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              core_rd,
  input  logic [DATA_W-1:0] core_wdata,
  inout  wire  [DATA_W-1:0] data_bus,
  output logic [ADDR_W-1:0] addr_bus,
  output logic              rw_line,
  output logic              bus_oe,
  output logic [DATA_W-1:0] in_data
);
  logic [DATA_W-1:0] wdata_q;
  logic              oe_q;

  tpbus_addr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk(clk), .rst(rst), .load(ph2_rise),
    .addr_in(core_addr), .wdata_in(core_wdata),
    .addr_q(addr_bus), .wdata_q(wdata_q)
  );

  tpbus_rw_stage u_rw (
    .clk(clk), .rst(rst), .open_en(ph1_level), .rd_req(core_rd),
    .rw_q(rw_line), .oe_q(oe_q)
  );

  tpbus_in_stage #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst(rst), .strobe(ph1_rise), .rd_req(core_rd),
    .bus_in(data_bus), .data_q(in_data)
  );

  assign bus_oe   = oe_q;
  assign data_bus = oe_q ? wdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/tpbus_if_chk.sv
module tpbus_if_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ph1_rise,
  input logic              ph2_rise,
  input logic              ph1_level,
  input logic [ADDR_W-1:0] core_addr,
  input logic              core_rd,
  input logic [DATA_W-1:0] core_wdata,
  input logic [DATA_W-1:0] data_bus,
  input logic [ADDR_W-1:0] addr_bus,
  input logic              rw_line,
  input logic              bus_oe,
  input logic [DATA_W-1:0] in_data
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (addr_bus == '0 && rw_line && !bus_oe && in_data == '0));
  a_r2_addr_load: assert property (@(posedge clk) disable iff (rst)
    ph2_rise |=> addr_bus == $past(core_addr));
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !ph2_rise |=> $stable(addr_bus));
  a_r4_rw_follow: assert property (@(posedge clk) disable iff (rst)
    ph1_level |=> rw_line == $past(core_rd));
  a_r5_rw_hold: assert property (@(posedge clk) disable iff (rst)
    !ph1_level |=> $stable(rw_line));
  a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    bus_oe == !rw_line);
  a_r7_drive_data: assert property (@(posedge clk) disable iff (rst)
    ph2_rise |=> (!bus_oe || data_bus == $past(core_wdata)));
  a_r8_capture: assert property (@(posedge clk) disable iff (rst)
    (ph1_rise && core_rd) |=> in_data == $past(data_bus));
  a_r9_in_hold: assert property (@(posedge clk) disable iff (rst)
    !(ph1_rise && core_rd) |=> $stable(in_data));
endmodule

bind tpbus_if tpbus_if_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ph1_rise(ph1_rise), .ph2_rise(ph2_rise),
  .ph1_level(ph1_level), .core_addr(core_addr), .core_rd(core_rd),
  .core_wdata(core_wdata), .data_bus(data_bus), .addr_bus(addr_bus),
  .rw_line(rw_line), .bus_oe(bus_oe), .in_data(in_data)
);

// File: tb/sim_tpbus_if.sv
`timescale 1ns/1ps
module sim_tpbus_if;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ph1_rise = 0, ph2_rise = 0, ph1_level = 0;
  logic [AW-1:0] core_addr = '0;
  logic core_rd = 1'b1;
  logic [DW-1:0] core_wdata = '0;
  logic [DW-1:0] dev_drv = '0;
  wire  [DW-1:0] data_bus;
  logic [AW-1:0] addr_bus;
  logic rw_line, bus_oe;
  logic [DW-1:0] in_data;

  int checks = 0, errors = 0;
  bit done = 0;

  // Device side drives the bus only while the line signals a read.
  assign data_bus = rw_line ? dev_drv : {DW{1'bz}};

  tpbus_if #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .ph1_rise(ph1_rise), .ph2_rise(ph2_rise),
    .ph1_level(ph1_level), .core_addr(core_addr), .core_rd(core_rd),
    .core_wdata(core_wdata), .data_bus(data_bus), .addr_bus(addr_bus),
    .rw_line(rw_line), .bus_oe(bus_oe), .in_data(in_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected state
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_wd, e_in;
  logic e_rw;

  function automatic logic [DW-1:0] bus_value(logic rw, logic [DW-1:0] dev, logic [DW-1:0] wd);
    return rw ? dev : wd;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: inputs already set; advance model, then check after the edge.
  task automatic tick();
    logic [DW-1:0] bv;
    bv = bus_value(e_rw, dev_drv, e_wd);
    @(posedge clk);
    if (rst) begin
      e_addr = '0; e_wd = '0; e_in = '0; e_rw = 1'b1;
    end else begin
      if (ph1_rise && core_rd) e_in = bv;
      if (ph2_rise) begin e_addr = core_addr; e_wd = core_wdata; end
      if (ph1_level) e_rw = core_rd;
    end
    @(negedge clk);
    chk("R2/R3 addr_bus", addr_bus, e_addr);
    chk("R4/R5 rw_line", rw_line, e_rw);
    chk("R6 bus_oe", bus_oe, !e_rw);
    chk("R8/R9 in_data", in_data, e_in);
    if (bus_oe) chk("R7 data_bus", data_bus, e_wd);
  endtask

  // One bus cycle of 8 clocks: ph2 rise at step 0, ph1 high steps 3..7.
  task automatic bus_cycle(logic rd, logic rand_rd_when_low);
    for (int s = 0; s < 8; s++) begin
      ph2_rise  = (s == 0);
      ph1_rise  = (s == 3);
      ph1_level = (s >= 3);
      if (s == 0) core_rd = rd;
      else if (rand_rd_when_low && s < 3) core_rd = $urandom_range(0, 1);
      else if (s == 3) core_rd = rd;
      core_addr  = AW'($urandom);
      core_wdata = DW'($urandom);
      dev_drv    = DW'($urandom);
      tick();
    end
  endtask

  task automatic run_same(logic rd, int n);
    bus_cycle(rd, 1'b0);
    for (int k = 1; k < n; k++) begin
      for (int s = 0; s < 8; s++) begin
        ph2_rise = (s == 0); ph1_rise = (s == 3); ph1_level = (s >= 3);
        core_rd = rd;
        core_addr = AW'($urandom); core_wdata = DW'($urandom); dev_drv = DW'($urandom);
        tick();
        chk("R10 steady rw_line", rw_line, rd);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    e_addr = '0; e_wd = '0; e_in = '0; e_rw = 1'b1;
    core_addr = 16'hBEEF; core_wdata = 8'h5A; core_rd = 1'b0;
    ph1_level = 1; ph2_rise = 1; ph1_rise = 1;
    tick(); tick();
    // R1: reset state despite active strobes
    chk("R1 addr_bus", addr_bus, '0);
    chk("R1 rw_line", rw_line, 1'b1);
    chk("R1 bus_oe", bus_oe, 1'b0);
    chk("R1 in_data", in_data, '0);
    rst = 0; ph1_level = 0; ph2_rise = 0; ph1_rise = 0; core_rd = 1'b1;
    tick();
    // Directed: write cycle drives bus, read cycle captures
    bus_cycle(1'b0, 1'b0);
    chk("R7 write drive", data_bus, e_wd);
    bus_cycle(1'b1, 1'b0);
    // Direction change requested while phase 1 low is ignored (R5)
    bus_cycle(1'b0, 1'b1);
    bus_cycle(1'b1, 1'b1);
    // R10: runs of same type
    run_same(1'b1, 5);
    run_same(1'b0, 5);
    // Random mix
    for (int i = 0; i < 300; i++) bus_cycle($urandom_range(0, 1), $urandom_range(0, 1));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule